// File: doc/BRIEF.md
# Non-volatile Image Checksum Engine

This block checks or repairs the integrity word of a 16-bit-word non-volatile memory image. It talks to the memory through a simple register-style access port. For each word it raises a one-cycle start strobe carrying the address, the direction and the write data. It then samples a done level at a fixed interval until the done level is seen or an attempt ceiling runs out. The memory is expected to drop done in the cycle after it sees the start strobe. It then raises done, together with read data and an error flag, and holds them until the next start.

The engine has two operations, chosen by `op_update` when `op_start` is accepted. Validate reads every word from address 0 up to and including the checksum location. It adds the words with 16-bit wrap-around and reports pass when the total equals 0xBABA. Update reads only the words below the checksum location. It then writes 0xBABA minus their wrapped sum into the checksum location, so that a later validate passes. Any memory error or poll timeout ends the operation at once with the error flag set.

When an operation ends, `done` pulses for one cycle. At that point `pass`, `err` and `sum_out` hold the result until the next accepted start. The checksum address, the address width, the poll interval and the attempt ceiling are parameters.

Top module: `nvm_csum_engine`

## Requirements
- R1: In validate (`op_update`=0) the engine reads addresses 0,1,...,CSUM_ADDR, each exactly once, in ascending order, and issues no write.
- R2: At the end of a validate without error, `pass`=1 exactly when the 16-bit wrapped sum of those words equals 0xBABA, and `sum_out` holds that sum.
- R3: In update (`op_update`=1) the engine reads addresses 0..CSUM_ADDR-1 only. It then issues exactly one write, to CSUM_ADDR, with data 0xBABA minus their wrapped sum. It ends with `pass`=1, `err`=0, and `sum_out` holding the sum of the lower words.
- R4: A memory error returned on any read or on the write ends the operation with no further access, with `err`=1 and `pass`=0.
- R5: If done is not seen within MAX_POLLS samples, the operation ends with `err`=1 and `pass`=0. Done rises MAX_POLLS*POLL_GAP+2 cycles after the cycle in which the stalled start strobe was seen.
- R6: `mem_start` is high for exactly one cycle per access. Done is sampled every POLL_GAP cycles, so a memory latency longer than one interval still completes normally.
- R7: `op_start` is ignored while `busy` is high: the running operation neither restarts nor changes mode, and no second operation follows.
- R8: After reset `busy`, `done`, `pass`, `err` and `mem_start` are 0. While `busy` is 0, `mem_start` stays 0.
- R9: `done` is a one-cycle pulse, and `busy` is 0 in the cycle after it.
- R10: The sum wraps modulo 2^16: `sum_out` equals the low 16 bits of the true sum even when that sum exceeds 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Request an operation (taken only when idle) |
| op_update | input | 1 | 0 = validate, 1 = update, sampled with op_start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| pass | output | 1 | Validate matched target, or update write succeeded |
| err | output | 1 | Operation aborted by memory error or poll timeout |
| sum_out | output | 16 | Wrapped sum of the words read |
| mem_start | output | 1 | One-cycle access strobe |
| mem_write | output | 1 | Access direction, 1 = write |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_wdata | output | 16 | Write data |
| mem_done | input | 1 | Access complete, held until the next start |
| mem_err | input | 1 | Access failed, valid with mem_done |
| mem_rdata | input | 16 | Read data, valid with mem_done |

## Verification
Validate is run on three images. One has a correct checksum word and a true sum far above 0xFFFF, so pass and the wrap-around can both be seen. A second is off by one from the target, which separates an exact compare from a loose one. The third is all zero, which shows that a zero total does not count as a pass. Update is run on an image whose checksum word is garbage. The single write is then checked against an independently computed complement, and a follow-up validate confirms it. Error injection on a middle read and on the final write, a never-answering memory, a memory latency longer than several poll intervals, and a start request issued mid-operation separate abort, timeout, multi-poll and ignore behaviour.

// File: rtl/nvm_csum_pkg.sv
package nvm_csum_pkg;

  localparam logic [15:0] CSUM_TARGET = 16'hBABA;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_FIN} csum_state_e;

  // wrapped 16-bit accumulation step
  function automatic logic [15:0] csum_add(input logic [15:0] a, input logic [15:0] b);
    return a + b;
  endfunction

  // word that brings a partial sum up to the target
  function automatic logic [15:0] csum_fix(input logic [15:0] partial);
    return CSUM_TARGET - partial;
  endfunction

  function automatic logic csum_ok(input logic [15:0] total);
    return total == CSUM_TARGET;
  endfunction

endpackage

// File: rtl/nvm_poll_port.sv
// One access at a time: strobe start, then sample done every POLL_GAP
// cycles, giving up after MAX_POLLS samples.
module nvm_poll_port #(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned MAX_POLLS = 100000,
  parameter int unsigned POLL_GAP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_write,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [15:0]       go_wdata,
  output logic              fin,
  output logic              fin_err,
  output logic [15:0]       fin_data,
  output logic              mem_start,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_done,
  input  logic              mem_err,
  input  logic [15:0]       mem_rdata
);
  localparam int TW = $clog2(MAX_POLLS + 1);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam logic [TW-1:0] LAST_TRY = TW'(MAX_POLLS - 1);
  localparam logic [GW-1:0] GAP_FULL = GW'(POLL_GAP);
  localparam logic [GW-1:0] GAP_NEXT = GW'(POLL_GAP - 1);

  logic          waiting;
  logic [GW-1:0] gap_cnt;
  logic [TW-1:0] tries;
  logic          sample_now;
  logic          out_of_tries;

  assign sample_now   = waiting && (gap_cnt == '0);
  assign out_of_tries = (tries == LAST_TRY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting   <= 1'b0;
      gap_cnt   <= '0;
      tries     <= '0;
      fin       <= 1'b0;
      fin_err   <= 1'b0;
      fin_data  <= '0;
      mem_start <= 1'b0;
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      fin       <= 1'b0;
      mem_start <= 1'b0;
      if (!waiting) begin
        if (go) begin
          mem_start <= 1'b1;
          mem_write <= go_write;
          mem_addr  <= go_addr;
          mem_wdata <= go_wdata;
          gap_cnt   <= GAP_FULL;
          tries     <= '0;
          waiting   <= 1'b1;
        end
      end else if (!sample_now) begin
        gap_cnt <= gap_cnt - 1'b1;
      end else if (mem_done) begin
        fin      <= 1'b1;
        fin_err  <= mem_err;
        fin_data <= mem_rdata;
        waiting  <= 1'b0;
      end else if (out_of_tries) begin
        fin      <= 1'b1;
        fin_err  <= 1'b1;
        waiting  <= 1'b0;
      end else begin
        tries   <= tries + 1'b1;
        gap_cnt <= GAP_NEXT;
      end
    end
  end
endmodule

// File: rtl/nvm_sum_acc.sv
module nvm_sum_acc import nvm_csum_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        add_en,
  input  logic [15:0] add_val,
  output logic [15:0] sum,
  output logic [15:0] sum_next
);
  assign sum_next = csum_add(sum, add_val);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) sum <= '0;
    else if (add_en)   sum <= sum_next;
  end
endmodule

// File: rtl/nvm_csum_engine.sv
module nvm_csum_engine import nvm_csum_pkg::*; #(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned CSUM_ADDR = 63,
  parameter int unsigned MAX_POLLS = 100000,
  parameter int unsigned POLL_GAP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic              op_update,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              err,
  output logic [15:0]       sum_out,
  output logic              mem_start,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_done,
  input  logic              mem_err,
  input  logic [15:0]       mem_rdata
);
  localparam logic [ADDR_W-1:0] CS_A        = ADDR_W'(CSUM_ADDR);
  localparam bit                UPD_NO_READ = (CSUM_ADDR == 0);
  localparam logic [ADDR_W-1:0] UPD_LAST    = UPD_NO_READ ? '0 : ADDR_W'(CSUM_ADDR - 1);

  csum_state_e       state;
  logic              mode_upd;
  logic [ADDR_W-1:0] idx;
  logic              go_q, go_wr_q;
  logic [ADDR_W-1:0] go_addr_q;
  logic [15:0]       go_wdata_q;

  // named internal events
  logic        fin, fin_err;
  logic [15:0] fin_data;
  logic        accept, word_ok, rd_last;
  logic [15:0] acc_next;

  assign accept  = (state == ST_IDLE) && op_start;
  assign word_ok = (state == ST_READ) && fin && !fin_err;
  assign rd_last = mode_upd ? (idx == UPD_LAST) : (idx == CS_A);

  nvm_poll_port #(.ADDR_W(ADDR_W), .MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP)) port_i (
    .clk(clk), .rst_n(rst_n),
    .go(go_q), .go_write(go_wr_q), .go_addr(go_addr_q), .go_wdata(go_wdata_q),
    .fin(fin), .fin_err(fin_err), .fin_data(fin_data),
    .mem_start(mem_start), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_done(mem_done), .mem_err(mem_err), .mem_rdata(mem_rdata)
  );

  nvm_sum_acc acc_i (
    .clk(clk), .rst_n(rst_n), .clr(accept), .add_en(word_ok), .add_val(fin_data),
    .sum(sum_out), .sum_next(acc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mode_upd   <= 1'b0;
      idx        <= '0;
      go_q       <= 1'b0;
      go_wr_q    <= 1'b0;
      go_addr_q  <= '0;
      go_wdata_q <= '0;
      pass       <= 1'b0;
      err        <= 1'b0;
    end else begin
      go_q <= 1'b0;
      case (state)
        ST_IDLE: if (op_start) begin
          mode_upd <= op_update;
          idx      <= '0;
          pass     <= 1'b0;
          err      <= 1'b0;
          go_q     <= 1'b1;
          if (op_update && UPD_NO_READ) begin
            go_wr_q    <= 1'b1;
            go_addr_q  <= CS_A;
            go_wdata_q <= csum_fix(16'h0000);
            state      <= ST_WRITE;
          end else begin
            go_wr_q   <= 1'b0;
            go_addr_q <= '0;
            state     <= ST_READ;
          end
        end
        ST_READ: if (fin) begin
          if (fin_err) begin
            err   <= 1'b1;
            state <= ST_FIN;
          end else if (rd_last) begin
            if (mode_upd) begin
              go_q       <= 1'b1;
              go_wr_q    <= 1'b1;
              go_addr_q  <= CS_A;
              go_wdata_q <= csum_fix(acc_next);
              state      <= ST_WRITE;
            end else begin
              pass  <= csum_ok(acc_next);
              state <= ST_FIN;
            end
          end else begin
            idx       <= idx + 1'b1;
            go_q      <= 1'b1;
            go_wr_q   <= 1'b0;
            go_addr_q <= idx + 1'b1;
          end
        end
        ST_WRITE: if (fin) begin
          err   <= fin_err;
          pass  <= !fin_err;
          state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);
endmodule

// File: rtl/nvm_csum_engine_chk.sv
module nvm_csum_engine_chk #(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned CSUM_ADDR = 63
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_start,
  input logic              op_update,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              err,
  input logic [15:0]       sum_out,
  input logic              mem_start,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam logic [ADDR_W-1:0] CS_A = ADDR_W'(CSUM_ADDR);

  logic            mode_q;
  logic [ADDR_W:0] nxt_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      nxt_rd <= '0;
    end else begin
      if (!busy && op_start) mode_q <= op_update;
      if (!busy) nxt_rd <= '0;
      else if (mem_start && !mem_write) nxt_rd <= {1'b0, mem_addr} + 1'b1;
    end
  end

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_start && !done));
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_start |=> !mem_start);
  assert_read_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_start && !mem_write) |-> ({1'b0, mem_addr} == nxt_rd));
  assert_write_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_start && mem_write) |-> (mode_q && mem_addr == CS_A));
  assert_validate_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q && !err) |-> (pass == (sum_out == 16'hBABA)));
  assert_abort_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(pass && err));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind nvm_csum_engine nvm_csum_engine_chk #(.ADDR_W(ADDR_W), .CSUM_ADDR(CSUM_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_update(op_update),
  .busy(busy), .done(done), .pass(pass), .err(err), .sum_out(sum_out),
  .mem_start(mem_start), .mem_write(mem_write), .mem_addr(mem_addr)
);

// File: tb/nvm_csum_engine_tb_top.sv
`timescale 1ns/1ps
module nvm_csum_engine_tb_top;
  localparam int ADDR_W = 6;
  localparam int CSUM_ADDR = 63;
  localparam int MAX_POLLS = 8;
  localparam int POLL_GAP = 3;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 1'b0, op_update = 1'b0;
  logic busy, done, pass, err;
  logic [15:0] sum_out;
  logic mem_start, mem_write;
  logic [ADDR_W-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic mem_done, mem_err;
  logic [15:0] mem_rdata;

  always #4 clk = ~clk;

  nvm_csum_engine #(.ADDR_W(ADDR_W), .CSUM_ADDR(CSUM_ADDR), .MAX_POLLS(MAX_POLLS),
                    .POLL_GAP(POLL_GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_update(op_update),
    .busy(busy), .done(done), .pass(pass), .err(err), .sum_out(sum_out),
    .mem_start(mem_start), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_done(mem_done), .mem_err(mem_err), .mem_rdata(mem_rdata)
  );

  // ---------------- memory model ----------------
  logic [15:0] img [0:DEPTH-1];
  int  lat = 2;
  bit  stall = 0, inj = 0;
  int  inj_addr = 0;
  int  n_acc, n_rd, n_wr, cyc, t_start;
  bit  ord_bad;
  int  w_addr;
  logic [15:0] w_data;
  bit  pend, p_we;
  int  cnt;
  logic [ADDR_W-1:0] p_addr;
  logic [15:0] p_wd;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mem_done <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0; pend <= 1'b0;
    end else if (mem_start) begin
      mem_done <= 1'b0; mem_err <= 1'b0;
      pend <= !stall; cnt <= lat;
      p_addr <= mem_addr; p_we <= mem_write; p_wd <= mem_wdata;
      t_start <= cyc;
      n_acc <= n_acc + 1;
      if (mem_write) begin
        n_wr <= n_wr + 1; w_addr <= int'(mem_addr); w_data <= mem_wdata;
      end else begin
        if (int'(mem_addr) != n_rd) ord_bad <= 1'b1;
        n_rd <= n_rd + 1;
      end
    end else if (pend) begin
      if (cnt == 0) begin
        pend <= 1'b0;
        mem_done <= 1'b1;
        mem_err <= inj && (int'(p_addr) == inj_addr);
        if (!p_we) mem_rdata <= img[p_addr];
        else if (!(inj && int'(p_addr) == inj_addr)) img[p_addr] <= p_wd;
      end else cnt <= cnt - 1;
    end
  end

  // ---------------- bench bookkeeping ----------------
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int cyc_done;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_stats();
    n_acc = 0; n_rd = 0; n_wr = 0; ord_bad = 0; w_addr = -1; w_data = '0;
  endtask

  task automatic load_img(input int mul, input int add);
    for (int i = 0; i < DEPTH; i++) img[i] = 16'(i * mul + add);
  endtask

  function automatic longint raw_sum(input int n);
    longint s = 0;
    for (int i = 0; i < n; i++) s += longint'(img[i]);
    return s;
  endfunction

  // issue one operation and wait for done (sampled at negedge)
  task automatic run_op(input bit upd, output bit seen);
    clr_stats();
    @(negedge clk); op_start = 1'b1; op_update = upd;
    @(negedge clk); op_start = 1'b0;
    seen = 0;
    for (int k = 0; k < 6000 && !seen; k++) begin
      if (done) begin seen = 1; cyc_done = cyc; end
      else @(negedge clk);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(!busy && !done && !pass && !err && !mem_start, "R8", "reset outputs",
        {busy, done, pass, err, mem_start}, 0);
  endtask

  task automatic t_validate_good();
    bit seen; longint s;
    load_img(16'h1F3B, 16'h4D21);
    img[CSUM_ADDR] = 16'hBABA - 16'(raw_sum(CSUM_ADDR));
    s = raw_sum(CSUM_ADDR + 1);
    run_op(0, seen);
    chk(seen, "R2", "validate good finished", seen, 1);
    chk(pass && !err, "R2", "validate good pass", {pass, err}, 2'b10);
    chk(sum_out == 16'hBABA, "R2", "validate good sum", sum_out, 16'hBABA);
    chk(s > 64'hFFFF && sum_out == 16'(s), "R10", "wrapped sum", sum_out, 16'(s));
    chk(n_rd == CSUM_ADDR + 1 && !ord_bad, "R1", "read count/order", n_rd, CSUM_ADDR + 1);
    chk(n_wr == 0, "R1", "no write in validate", n_wr, 0);
    @(negedge clk);
    chk(!done && !busy, "R9", "done one cycle", {done, busy}, 0);
  endtask

  task automatic t_validate_bad();
    bit seen; longint s;
    load_img(16'h0777, 16'h9001);
    img[CSUM_ADDR] = 16'hBABA - 16'(raw_sum(CSUM_ADDR)) + 16'h0001;
    s = raw_sum(CSUM_ADDR + 1);
    run_op(0, seen);
    chk(seen && !pass && !err, "R2", "off-by-one fails", {seen, pass, err}, 3'b100);
    chk(sum_out == 16'(s), "R10", "off-by-one sum", sum_out, 16'(s));
    for (int i = 0; i < DEPTH; i++) img[i] = 16'h0000;
    run_op(0, seen);
    chk(seen && !pass && !err && sum_out == 16'h0, "R2", "zero image fails",
        {pass, err, sum_out}, 0);
  endtask

  task automatic t_update();
    bit seen; logic [15:0] s, fix;
    load_img(16'h3C5A, 16'hF00D);
    img[CSUM_ADDR] = 16'hDEAD;
    s = 16'(raw_sum(CSUM_ADDR));
    fix = 16'hBABA - s;
    run_op(1, seen);
    chk(seen && pass && !err, "R3", "update ok", {seen, pass, err}, 3'b110);
    chk(n_rd == CSUM_ADDR && !ord_bad, "R3", "update read count", n_rd, CSUM_ADDR);
    chk(n_wr == 1 && w_addr == CSUM_ADDR, "R3", "single write addr", w_addr, CSUM_ADDR);
    chk(w_data == fix, "R3", "write data", w_data, fix);
    chk(sum_out == s, "R3", "update sum_out", sum_out, s);
    run_op(0, seen);
    chk(seen && pass && !err, "R3", "validate after update", {pass, err}, 2'b10);
  endtask

  task automatic t_read_error();
    bit seen;
    load_img(16'h0101, 16'h0003);
    inj = 1; inj_addr = 10;
    run_op(0, seen);
    inj = 0;
    chk(seen && err && !pass, "R4", "read error flags", {seen, err, pass}, 3'b110);
    chk(n_acc == 11, "R4", "no access after error", n_acc, 11);
    repeat (10) @(negedge clk);
    chk(!busy && n_acc == 11, "R4", "stays idle after abort", n_acc, 11);
  endtask

  task automatic t_write_error();
    bit seen;
    load_img(16'h0202, 16'h0007);
    img[CSUM_ADDR] = 16'h1234;
    inj = 1; inj_addr = CSUM_ADDR;
    run_op(1, seen);
    inj = 0;
    chk(seen && err && !pass, "R4", "write error flags", {seen, err, pass}, 3'b110);
    chk(img[CSUM_ADDR] == 16'h1234, "R4", "failed write leaves word", img[CSUM_ADDR], 16'h1234);
  endtask

  task automatic t_timeout();
    bit seen; int d;
    stall = 1;
    run_op(0, seen);
    stall = 0;
    d = cyc_done - t_start;
    chk(seen && err && !pass, "R5", "timeout flags", {seen, err, pass}, 3'b110);
    chk(n_acc == 1, "R5", "single stalled access", n_acc, 1);
    chk(d >= MAX_POLLS * POLL_GAP && d <= MAX_POLLS * POLL_GAP + 4, "R5", "timeout delay",
        d, MAX_POLLS * POLL_GAP + 2);
  endtask

  task automatic t_slow_memory();
    bit seen;
    load_img(16'h0055, 16'h1111);
    img[CSUM_ADDR] = 16'hBABA - 16'(raw_sum(CSUM_ADDR));
    lat = 15;
    run_op(0, seen);
    lat = 2;
    chk(seen && pass && !err, "R6", "slow memory multi-poll", {seen, pass, err}, 3'b110);
  endtask

  task automatic t_ignore_busy();
    bit seen;
    load_img(16'h0909, 16'h0A0A);
    img[CSUM_ADDR] = 16'hBABA - 16'(raw_sum(CSUM_ADDR));
    clr_stats();
    @(negedge clk); op_start = 1'b1; op_update = 1'b0;
    @(negedge clk); op_start = 1'b0;
    repeat (40) @(negedge clk);
    op_start = 1'b1; op_update = 1'b1;
    @(negedge clk); op_start = 1'b0; op_update = 1'b0;
    seen = 0;
    for (int k = 0; k < 6000 && !seen; k++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    chk(seen && pass && !err, "R7", "op completes as validate", {seen, pass, err}, 3'b110);
    chk(n_wr == 0 && n_rd == CSUM_ADDR + 1, "R7", "no restart/mode change", n_rd, CSUM_ADDR + 1);
    repeat (20) @(negedge clk);
    chk(!busy && n_acc == CSUM_ADDR + 1, "R7", "no queued operation", n_acc, CSUM_ADDR + 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    cyc = 0; t_start = 0;
    clr_stats();
    for (int i = 0; i < DEPTH; i++) img[i] = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_validate_good();
    t_validate_bad();
    t_update();
    t_read_error();
    t_write_error();
    t_timeout();
    t_slow_memory();
    t_ignore_busy();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule